// File: doc/BRIEF.md
# Erase-Count Wear-Leveling Allocator

This block hands out spare flash blocks to a small flash translation controller and keeps wear even across the device. Every physical block has one saturating erase counter. All spare blocks sit in a single global free bitmap. After every erase, a scanner walks the table one entry per clock. It finds the in-use block with the fewest erases, which is taken as the holder of cold, rarely rewritten data, and records its index as the static pointer.

On an allocation request the lowest-index free block is removed from the pool, and its erase count is compared with a programmable wear threshold. If the count is strictly above the threshold and a static block is known, the block raises a swap request. That request asks the controller to move the static data onto the worn block. The grant is issued only after the swap request has been accepted. Data movement, flash command sequencing and address mapping belong to other blocks.

Top module: `wear_level_alloc`

## Requirements
- R1: After reset, every block is free, every erase count is zero, the wear threshold is all ones, and both `alloc_gnt` and `swap_valid` are low.
- R2: An `erase_vld` cycle adds one to the erase count of block `erase_idx`. The count saturates at 2^CNT_W-1 (65535 by default) and never wraps.
- R3: An erased block goes back into the free pool and can be allocated again.
- R4: While `alloc_req` is high, the block removes the lowest-index free block from the pool. It reports that block on `alloc_idx` with `alloc_gnt` high for exactly one cycle.
- R5: While the pool is empty, a pending request gets no grant. The request is served as soon as an erase frees a block.
- R6: After each erase, the static pointer is recomputed over all blocks. It is the in-use block with the smallest count, with ties going to the lowest index, and free blocks are skipped. An allocation does not begin while this scan is running.
- R7: If the allocated block's count is strictly greater than the threshold, `swap_valid` rises before the grant, with `swap_src` set to the static pointer and `swap_dst` set to the allocated block. A count equal to the threshold raises no swap.
- R8: `swap_valid` and its indices stay stable until `swap_ready` is seen high. The grant follows in the next cycle, `swap_valid` is low by then, and grant and swap are never high together.
- R9: When no block is in use there is no static pointer, and an over-threshold allocation is granted without a swap.
- R10: A write with `thresh_we` loads `thresh_val` as the threshold used by every later allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request, held until granted |
| alloc_gnt | output | 1 | One-cycle grant |
| alloc_idx | output | IDX_W (6) | Granted block index |
| erase_vld | input | 1 | Erase-done notification |
| erase_idx | input | IDX_W (6) | Erased block index |
| thresh_we | input | 1 | Threshold write strobe |
| thresh_val | input | CNT_W (16) | New threshold value |
| swap_valid | output | 1 | Swap request valid |
| swap_ready | input | 1 | Swap request accepted |
| swap_src | output | IDX_W (6) | Static block (data source) |
| swap_dst | output | IDX_W (6) | Over-worn block (destination) |

## Verification
The bench targets the boundary between a count equal to the threshold and one just above it. A comparator using >= would raise a spurious swap at equality. It erases one block past 65535 times: a wrapping counter would then look young and suppress a swap that must occur. It builds tables in which free blocks hold lower counts than any in-use block. A scanner that forgot to skip free blocks, or broke ties toward the higher index, would name the wrong swap source. Finally, it stalls `swap_ready`, drains the pool completely, and frees every block. A design that granted early, granted from an empty pool, or swapped with no static block would each be seen at the ports.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SWAP  = 2'd2,
    ST_GRANT = 2'd3
  } alloc_st_e;
endpackage

// File: rtl/wl_cnt_table.sv
module wl_cnt_table #(
  parameter int N     = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CNT_W-1:0] rd_a_cnt,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CNT_W-1:0] rd_b_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else if (inc_en && cnt_q[inc_idx] != CNT_MAX) begin
      cnt_q[inc_idx] <= cnt_q[inc_idx] + 1'b1;
    end
  end

  assign rd_a_cnt = cnt_q[rd_a_idx];
  assign rd_b_cnt = cnt_q[rd_b_idx];

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_en && cnt_q[inc_idx] == CNT_MAX) |=> (cnt_q[$past(inc_idx)] == CNT_MAX));
endmodule

// File: rtl/wl_free_pool.sv
module wl_free_pool #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_en,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             give_en,
  input  logic [IDX_W-1:0] give_idx,
  output logic [N-1:0]     free_o,
  output logic [IDX_W-1:0] low_idx,
  output logic             any_free
);
  logic [N-1:0] free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
    end else begin
      if (take_en) free_q[take_idx] <= 1'b0;
      if (give_en) free_q[give_idx] <= 1'b1;
    end
  end

  always_comb begin
    low_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        low_idx  = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign free_o = free_q;

  // R4
  take_free_chk: assert property (@(posedge clk) disable iff (rst)
    take_en |-> free_q[take_idx]);
endmodule

// File: rtl/wl_min_scan.sv
module wl_min_scan #(
  parameter int N     = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N-1:0]     free_i,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             busy,
  output logic             ptr_vld,
  output logic [IDX_W-1:0] ptr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             busy_q;
  logic [IDX_W-1:0] pos_q;
  logic             best_vld_q;
  logic [IDX_W-1:0] best_idx_q;
  logic [CNT_W-1:0] best_cnt_q;
  logic             ptr_vld_q;
  logic [IDX_W-1:0] ptr_idx_q;

  logic             better;
  logic             nb_vld;
  logic [IDX_W-1:0] nb_idx;
  logic [CNT_W-1:0] nb_cnt;

  assign rd_idx = pos_q;
  assign better = busy_q && !free_i[pos_q] && (!best_vld_q || rd_cnt < best_cnt_q);

  always_comb begin
    nb_vld = best_vld_q;
    nb_idx = best_idx_q;
    nb_cnt = best_cnt_q;
    if (better) begin
      nb_vld = 1'b1;
      nb_idx = pos_q;
      nb_cnt = rd_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      pos_q      <= '0;
      best_vld_q <= 1'b0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      ptr_vld_q  <= 1'b0;
      ptr_idx_q  <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      pos_q      <= '0;
      best_vld_q <= 1'b0;
    end else if (busy_q) begin
      best_vld_q <= nb_vld;
      best_idx_q <= nb_idx;
      best_cnt_q <= nb_cnt;
      pos_q      <= pos_q + 1'b1;
      if (pos_q == LAST) begin
        busy_q    <= 1'b0;
        ptr_vld_q <= nb_vld;
        ptr_idx_q <= nb_idx;
      end
    end
  end

  assign busy    = busy_q;
  assign ptr_vld = ptr_vld_q;
  assign ptr_idx = ptr_idx_q;

  // R6
  ptr_inuse_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && ptr_vld_q) |-> !free_i[ptr_idx_q]);
endmodule

// File: rtl/wear_level_alloc.sv
module wear_level_alloc #(
  parameter int N     = 64,
  parameter int CNT_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             erase_vld,
  input  logic [IDX_W-1:0] erase_idx,
  input  logic             thresh_we,
  input  logic [CNT_W-1:0] thresh_val,
  output logic             swap_valid,
  input  logic             swap_ready,
  output logic [IDX_W-1:0] swap_src,
  output logic [IDX_W-1:0] swap_dst
);
  import wl_pkg::*;

  alloc_st_e        st_q;
  logic [IDX_W-1:0] pick_q;
  logic [CNT_W-1:0] thresh_q;
  logic [IDX_W-1:0] src_q;
  logic [IDX_W-1:0] dst_q;

  logic [N-1:0]     free_w;
  logic [IDX_W-1:0] low_idx;
  logic             any_free;
  logic             take_en;
  logic [CNT_W-1:0] pick_cnt;
  logic [IDX_W-1:0] scan_idx;
  logic [CNT_W-1:0] scan_cnt;
  logic             scan_busy;
  logic             ptr_vld;
  logic [IDX_W-1:0] ptr_idx;
  logic             over;

  wl_cnt_table #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .inc_en(erase_vld), .inc_idx(erase_idx),
    .rd_a_idx(pick_q), .rd_a_cnt(pick_cnt),
    .rd_b_idx(scan_idx), .rd_b_cnt(scan_cnt)
  );

  wl_free_pool #(.N(N), .IDX_W(IDX_W)) u_pool (
    .clk(clk), .rst(rst),
    .take_en(take_en), .take_idx(low_idx),
    .give_en(erase_vld), .give_idx(erase_idx),
    .free_o(free_w), .low_idx(low_idx), .any_free(any_free)
  );

  wl_min_scan #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst),
    .start(erase_vld), .free_i(free_w),
    .rd_idx(scan_idx), .rd_cnt(scan_cnt),
    .busy(scan_busy), .ptr_vld(ptr_vld), .ptr_idx(ptr_idx)
  );

  assign take_en = (st_q == ST_IDLE) && alloc_req && any_free && !scan_busy && !erase_vld;
  assign over    = pick_cnt > thresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_q <= '1;
    end else if (thresh_we) begin
      thresh_q <= thresh_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pick_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (take_en) begin
            pick_q <= low_idx;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (over && ptr_vld) begin
            src_q <= ptr_idx;
            dst_q <= pick_q;
            st_q  <= ST_SWAP;
          end else begin
            st_q <= ST_GRANT;
          end
        end
        ST_SWAP: begin
          if (swap_ready) st_q <= ST_GRANT;
        end
        ST_GRANT: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign alloc_gnt  = (st_q == ST_GRANT);
  assign alloc_idx  = pick_q;
  assign swap_valid = (st_q == ST_SWAP);
  assign swap_src   = src_q;
  assign swap_dst   = dst_q;

  // R8
  swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (swap_valid && !swap_ready) |=> (swap_valid && $stable(swap_src) && $stable(swap_dst)));
  // R8
  swap_to_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (swap_valid && swap_ready) |=> (alloc_gnt && !swap_valid));
  // R8
  gnt_swap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(alloc_gnt && swap_valid));
  // R4
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |=> !alloc_gnt);
  // R7
  swap_pair_chk: assert property (@(posedge clk) disable iff (rst)
    swap_valid |-> (swap_src != swap_dst));
endmodule

// File: tb/wear_level_alloc_bench.sv
module wear_level_alloc_bench;
  localparam int N = 64;
  localparam int CW = 16;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_req = 1'b0;
  logic          alloc_gnt;
  logic [IW-1:0] alloc_idx;
  logic          erase_vld = 1'b0;
  logic [IW-1:0] erase_idx = '0;
  logic          thresh_we = 1'b0;
  logic [CW-1:0] thresh_val = '0;
  logic          swap_valid;
  logic          swap_ready = 1'b0;
  logic [IW-1:0] swap_src;
  logic [IW-1:0] swap_dst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wear_level_alloc #(.N(N), .CNT_W(CW)) u_wear_level_alloc (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .erase_vld(erase_vld), .erase_idx(erase_idx),
    .thresh_we(thresh_we), .thresh_val(thresh_val),
    .swap_valid(swap_valid), .swap_ready(swap_ready),
    .swap_src(swap_src), .swap_dst(swap_dst)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_thresh(input int v);
    @(negedge clk);
    thresh_we = 1'b1;
    thresh_val = CW'(v);
    @(negedge clk);
    thresh_we = 1'b0;
  endtask

  task automatic erase(input int idx, input int times);
    @(negedge clk);
    for (int k = 0; k < times; k++) begin
      erase_vld = 1'b1;
      erase_idx = IW'(idx);
      @(negedge clk);
    end
    erase_vld = 1'b0;
  endtask

  task automatic do_alloc(input int exp_idx, input bit exp_swap, input int exp_src,
                          input int stall, input string req);
    bit saw = 1'b0;
    bit got = 1'b0;
    int n = 0;
    alloc_req = 1'b1;
    while (!got && n < 2000) begin
      @(negedge clk);
      n++;
      if (alloc_gnt) begin
        got = 1'b1;
        alloc_req = 1'b0;
        swap_ready = 1'b0;
        chk(!swap_valid, "R8", "swap_valid low at grant", int'(swap_valid), 0);
      end else if (swap_valid && !saw) begin
        saw = 1'b1;
        chk(int'(swap_src) == exp_src, req, "swap_src", int'(swap_src), exp_src);
        chk(int'(swap_dst) == exp_idx, req, "swap_dst", int'(swap_dst), exp_idx);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          n++;
          chk(swap_valid && !alloc_gnt, "R8", "swap held while not ready", int'(swap_valid), 1);
          chk(int'(swap_src) == exp_src, "R8", "swap_src stable", int'(swap_src), exp_src);
        end
        swap_ready = 1'b1;
      end
    end
    alloc_req = 1'b0;
    swap_ready = 1'b0;
    chk(got, req, "grant seen", int'(got), 1);
    chk(int'(alloc_idx) == exp_idx, req, "alloc_idx", int'(alloc_idx), exp_idx);
    chk(saw == exp_swap, req, "swap raised", int'(saw), int'(exp_swap));
    @(negedge clk);
    chk(!alloc_gnt, "R4", "grant one cycle", int'(alloc_gnt), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!alloc_gnt, "R1", "gnt after reset", int'(alloc_gnt), 0);
    chk(!swap_valid, "R1", "swap after reset", int'(swap_valid), 0);
  endtask

  task automatic t_lowest();
    for (int i = 0; i < 4; i++) do_alloc(i, 1'b0, 0, 0, "R4");
  endtask

  task automatic t_swap_over();
    erase(2, 3);
    set_thresh(2);
    do_alloc(2, 1'b1, 0, 3, "R7");
  endtask

  task automatic t_equal();
    erase(1, 3);
    set_thresh(3);
    do_alloc(1, 1'b0, 0, 0, "R7");
  endtask

  task automatic t_scan_excl();
    erase(0, 2);
    erase(3, 1);
    set_thresh(1);
    do_alloc(0, 1'b1, 1, 1, "R6");
    do_alloc(3, 1'b0, 0, 0, "R3");
  endtask

  task automatic t_empty();
    set_thresh(65535);
    for (int i = 4; i < N; i++) do_alloc(i, 1'b0, 0, 0, "R4");
    alloc_req = 1'b1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (alloc_gnt) chk(1'b0, "R5", "grant from empty pool", 1, 0);
    end
    chk(!alloc_gnt, "R5", "no grant while empty", int'(alloc_gnt), 0);
    erase(10, 1);
    do_alloc(10, 1'b0, 0, 0, "R5");
  endtask

  task automatic t_sat();
    erase(5, 65540);
    do_alloc(5, 1'b0, 0, 0, "R2");
    erase(5, 1);
    set_thresh(65534);
    do_alloc(5, 1'b1, 4, 0, "R2");
  endtask

  task automatic t_nostatic();
    for (int i = 0; i < N; i++) erase(i, 1);
    set_thresh(0);
    do_alloc(0, 1'b0, 0, 0, "R9");
  endtask

  task automatic t_reset_clear();
    t_reset();
    set_thresh(1);
    do_alloc(0, 1'b0, 0, 0, "R1");
    do_alloc(1, 1'b0, 0, 0, "R1");
    erase(0, 1);
    do_alloc(0, 1'b0, 0, 0, "R1");
    erase(0, 1);
    do_alloc(0, 1'b1, 1, 0, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lowest();
    t_swap_over();
    t_equal();
    t_scan_excl();
    t_empty();
    t_sat();
    t_nostatic();
    t_reset_clear();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule